// File: doc/BRIEF.md
# HDLC Link-Channel Transmit Controller

This block turns software-written message bytes into an HDLC bit stream for a low-rate maintenance link. The link rides in spare overhead bit positions of a framed line signal. Software pushes bytes one at a time into a 16-entry transmit FIFO. It sets an end-of-message flag on the write that carries the final byte. The controller puts a flag octet before each frame and bit-stuffs the payload. It then appends a complemented CRC-16 check sequence and a closing flag. Whenever it has nothing to send, it fills the link with flag octets.

The serializer has no bit clock of its own. The line framer asserts a one-cycle slot strobe for each overhead bit position. On each strobe the controller presents one bit and then advances, and between strobes its output holds. When the controller is disabled, its FIFO is emptied, its status outputs are forced inactive, and the slot bit is taken from one of two other sources, chosen by a mode input.

Top module: `hdlc_link_tx`

## Requirements
- R1: While `enable` is 0, `slot_bit` equals `ext_bit` when `alt_sel` is 0 and equals `stuff_bit` when `alt_sel` is 1, in the same cycle.
- R2: A clock edge with `enable` at 0 empties the FIFO and clears `ovf_flag`. Writes made while disabled are discarded. On re-enable, the serializer starts with a fresh flag octet.
- R3: While no frame is in progress and the FIFO is empty, the controller sends back-to-back flag octets 0x7E, least significant bit first. Flag bits are never stuffed.
- R4: The serial position advances by exactly one bit at each clock edge where `slot_stb` is 1 and `enable` is 1. `slot_bit` does not change between strobes.
- R5: A frame starts right after a flag octet has finished and the FIFO holds a byte. The payload bytes go out in write order, least significant bit first.
- R6: After five consecutive 1 bits of payload or check sequence, one 0 bit is inserted. A stuff bit that falls due after the last check-sequence bit is still sent, ahead of the closing flag.
- R7: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1 (bit-reversed constant 0x8408), preset to 0xFFFF, computed over the payload bits in line order and ones-complemented. Its low byte is sent first, then its high byte, each least significant bit first, then one closing flag octet.
- R8: `wr_eom`=1 on a write marks that byte as the frame's last. If the FIFO is empty when the next payload byte is due, the frame also ends there, with its check sequence and closing flag.
- R9: The FIFO holds 16 bytes. A write to a full FIFO is dropped and sets `ovf_flag`, which stays set until the controller is disabled.
- R10: `irq_low` is 1 exactly when `enable` is 1 and `fifo_level` is below 4.
- R11: `fifo_level` reports the number of stored bytes. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; 0 flushes it and selects an alternate slot source |
| alt_sel | input | 1 | Alternate source select while disabled: 0 external bit, 1 stuffing logic |
| ext_bit | input | 1 | External slot bit |
| stuff_bit | input | 1 | Slot bit from internal stuffing logic |
| slot_stb | input | 1 | One-cycle strobe marking an overhead link bit slot |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Byte to enqueue |
| wr_eom | input | 1 | Marks the written byte as the last of its message |
| slot_bit | output | 1 | Bit for the current overhead slot |
| irq_low | output | 1 | FIFO below threshold interrupt |
| ovf_flag | output | 1 | Sticky FIFO overflow status |
| fifo_level | output | 5 | Bytes held in the FIFO |

## Verification
The assertions assume that `slot_stb` is a synchronous pulse with no timing relation to the clock beyond being sampled at edges. They also assume that `enable` and the write inputs change only between edges, and that nothing but a strobe may move the serial output. The stimulus drives every input shortly after the rising edge. It varies strobe density from every cycle down to roughly one in three. It fills the FIFO with strobes paused so that overflow occurs, and it drops `enable` in the middle of a frame. Payloads include runs of ones that cross byte borders and reach into the check sequence, so that stuffing happens at octet ends.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam logic [7:0]  FLAG_OCTET     = 8'h7E;
    localparam logic [15:0] CRC_POLY_REFL  = 16'h8408;
    localparam logic [15:0] CRC_PRESET     = 16'hFFFF;
    localparam int          STUFF_RUN      = 5;

    typedef enum logic [1:0] {
        OCT_FLAG,
        OCT_DATA,
        OCT_FCS_LO,
        OCT_FCS_HI
    } oct_kind_e;

    typedef struct packed {
        logic       eom;
        logic [7:0] data;
    } fifo_word_t;

    // Reflected CRC-16 update over one byte, least significant bit first.
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  fifo_word_t       wr_word,
    input  logic             rd_en,
    output fifo_word_t       rd_word,
    output logic             empty,
    output logic [LVL_W-1:0] level,
    output logic             overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fifo_word_t       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             full, do_wr, do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (level == LVL_W'(DEPTH));
        empty   = (level == '0);
        do_wr   = wr_en && !full;
        do_rd   = rd_en && !empty;
        rd_word = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_wr && !flush && !rst) mem[wp] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp       <= '0;
            rp       <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr) wp <= bump(wp);
            if (do_rd) rp <= bump(rp);
            case ({do_wr, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (wr_en && full) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       stb,
    input  fifo_word_t head,
    input  logic       empty,
    output logic       pop,
    output logic       tx_bit
);
    logic [7:0]  sh;
    logic [2:0]  bit_idx;
    oct_kind_e   kind;
    logic [15:0] crc;
    logic        last_eom;
    logic [2:0]  ones;
    logic        stuff_pend;
    logic        oct_end, stuffable;

    always_comb begin
        tx_bit    = stuff_pend ? 1'b0 : sh[0];
        stuffable = (kind != OCT_FLAG);
        oct_end   = stb && !stuff_pend && (bit_idx == 3'd7);
        pop       = oct_end && !empty &&
                    ((kind == OCT_FLAG) || ((kind == OCT_DATA) && !last_eom));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sh         <= FLAG_OCTET;
            bit_idx    <= '0;
            kind       <= OCT_FLAG;
            crc        <= CRC_PRESET;
            last_eom   <= 1'b0;
            ones       <= '0;
            stuff_pend <= 1'b0;
        end else if (stb) begin
            if (stuff_pend) begin
                stuff_pend <= 1'b0;
            end else begin
                if (stuffable && sh[0]) begin
                    if (ones == 3'(STUFF_RUN - 1)) begin
                        stuff_pend <= 1'b1;
                        ones       <= '0;
                    end else begin
                        ones <= ones + 1'b1;
                    end
                end else begin
                    ones <= '0;
                end
                if (bit_idx == 3'd7) begin
                    bit_idx <= '0;
                    case (kind)
                        OCT_FLAG: begin
                            if (!empty) begin
                                sh       <= head.data;
                                kind     <= OCT_DATA;
                                crc      <= crc_byte(CRC_PRESET, head.data);
                                last_eom <= head.eom;
                            end else begin
                                sh <= FLAG_OCTET;
                            end
                        end
                        OCT_DATA: begin
                            if (!last_eom && !empty) begin
                                sh       <= head.data;
                                crc      <= crc_byte(crc, head.data);
                                last_eom <= head.eom;
                            end else begin
                                sh   <= ~crc[7:0];
                                kind <= OCT_FCS_LO;
                            end
                        end
                        OCT_FCS_LO: begin
                            sh   <= ~crc[15:8];
                            kind <= OCT_FCS_HI;
                        end
                        default: begin
                            sh   <= FLAG_OCTET;
                            kind <= OCT_FLAG;
                        end
                    endcase
                end else begin
                    sh      <= sh >> 1;
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_link_tx.sv
module hdlc_link_tx
    import hdlc_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LOW_MARK   = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             alt_sel,
    input  logic             ext_bit,
    input  logic             stuff_bit,
    input  logic             slot_stb,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wr_eom,
    output logic             slot_bit,
    output logic             irq_low,
    output logic             ovf_flag,
    output logic [LVL_W-1:0] fifo_level
);
    fifo_word_t in_word, head;
    logic       empty, pop, ser_bit;

    assign in_word = '{eom: wr_eom, data: wr_data};

    hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (!enable),
        .wr_en    (wr_en && enable),
        .wr_word  (in_word),
        .rd_en    (pop),
        .rd_word  (head),
        .empty    (empty),
        .level    (fifo_level),
        .overflow (ovf_flag)
    );

    hdlc_tx_ser u_ser (
        .clk    (clk),
        .rst    (rst),
        .run    (enable),
        .stb    (slot_stb),
        .head   (head),
        .empty  (empty),
        .pop    (pop),
        .tx_bit (ser_bit)
    );

    always_comb begin
        if (enable)       slot_bit = ser_bit;
        else if (alt_sel) slot_bit = stuff_bit;
        else              slot_bit = ext_bit;
        irq_low = enable && (fifo_level < LVL_W'(LOW_MARK));
    end

endmodule

// File: rtl/hdlc_link_tx_chk.sv
module hdlc_link_tx_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             slot_stb,
    input logic             slot_bit,
    input logic             irq_low,
    input logic             ovf_flag,
    input logic [LVL_W-1:0] fifo_level
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (seen && enable && $past(enable) && !$past(slot_stb)) |-> $stable(slot_bit)); // R4

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (seen && !enable) |=> (fifo_level == '0)); // R2

    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (seen && !$past(enable)) |-> !ovf_flag); // R2

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !irq_low); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(enable) && $past(ovf_flag)) |-> ovf_flag); // R9

    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_level) <= FIFO_DEPTH); // R9

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(enable)) |->
        (int'(fifo_level) <= int'($past(fifo_level)) + 1) &&
        (int'(fifo_level) + 1 >= int'($past(fifo_level)))); // R11

endmodule

bind hdlc_link_tx hdlc_link_tx_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .slot_stb   (slot_stb),
    .slot_bit   (slot_bit),
    .irq_low    (irq_low),
    .ovf_flag   (ovf_flag),
    .fifo_level (fifo_level)
);

// File: tb/tb_hdlc_link_tx.sv
module tb_hdlc_link_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LOWM       = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0, alt_sel = 1'b0, ext_bit = 1'b0, stuff_bit = 1'b0;
    logic       slot_stb = 1'b0, wr_en = 1'b0, wr_eom = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       slot_bit, irq_low, ovf_flag;
    logic [4:0] fifo_level;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    bit stb_on = 0;
    int stb_div = 1;

    hdlc_link_tx dut (
        .clk(clk), .rst(rst), .enable(enable), .alt_sel(alt_sel),
        .ext_bit(ext_bit), .stuff_bit(stuff_bit), .slot_stb(slot_stb),
        .wr_en(wr_en), .wr_data(wr_data), .wr_eom(wr_eom),
        .slot_bit(slot_bit), .irq_low(irq_low), .ovf_flag(ovf_flag),
        .fifo_level(fifo_level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    int mf_d[$];
    bit mf_e[$];
    bit mb[$];          // bits of the octet in flight
    int mk[$];          // 0 flag, 1 data, 2 check sequence
    int m_phase;        // 0 flag, 1 data, 2 fcs low, 3 fcs high
    int m_crc;
    bit m_last, m_pend, m_ovf;
    int m_ones;
    bit stb_at_edge;

    function automatic int crc_upd(int c, int b);
        for (int i = 0; i < 8; i++) begin
            int fb;
            fb = (c ^ (b >> i)) & 1;
            c  = c >> 1;
            if (fb != 0) c = c ^ 'h8408;
        end
        return c & 'hFFFF;
    endfunction

    function automatic void push_oct(int v, int kind);
        for (int i = 0; i < 8; i++) begin
            mb.push_back(bit'((v >> i) & 1));
            mk.push_back(kind);
        end
    endfunction

    function automatic void m_init();
        mf_d.delete(); mf_e.delete(); mb.delete(); mk.delete();
        m_phase = 0; m_crc = 'hFFFF; m_last = 0; m_pend = 0; m_ovf = 0; m_ones = 0;
        push_oct('h7E, 0);
    endfunction

    function automatic void m_next();
        case (m_phase)
            0: if (mf_d.size() > 0) begin
                   int d; d = mf_d.pop_front(); m_last = mf_e.pop_front();
                   m_crc = crc_upd('hFFFF, d); m_phase = 1; push_oct(d, 1);
               end else push_oct('h7E, 0);
            1: if (!m_last && mf_d.size() > 0) begin
                   int d; d = mf_d.pop_front(); m_last = mf_e.pop_front();
                   m_crc = crc_upd(m_crc, d); push_oct(d, 1);
               end else begin
                   m_phase = 2; push_oct((~m_crc) & 'hFF, 2);
               end
            2: begin m_phase = 3; push_oct(((~m_crc) >> 8) & 'hFF, 2); end
            default: begin m_phase = 0; push_oct('h7E, 0); end
        endcase
    endfunction

    always @(posedge clk) begin
        stb_at_edge = slot_stb;
        if (rst || !enable) begin
            m_init();
        end else begin
            bit acc;
            acc = wr_en && (mf_d.size() < DEPTH);
            if (wr_en && !acc) m_ovf = 1;
            if (slot_stb) begin
                if (m_pend) m_pend = 0;
                else begin
                    bit b; int k;
                    b = mb.pop_front(); k = mk.pop_front();
                    if (k != 0 && b) begin
                        m_ones++;
                        if (m_ones == 5) begin m_pend = 1; m_ones = 0; end
                    end else m_ones = 0;
                    if (mb.size() == 0) m_next();
                end
            end
            if (acc) begin mf_d.push_back(int'(wr_data)); mf_e.push_back(wr_eom); end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    bit prev_valid = 0, prev_bit, prev_en;

    always @(negedge clk) begin
        if (!rst && !done) begin
            int eb; string tag;
            if (!enable) begin eb = alt_sel ? int'(stuff_bit) : int'(ext_bit); tag = "R1 slot source"; end
            else if (m_pend) begin eb = 0; tag = "R6 stuff bit"; end
            else begin
                eb = int'(mb[0]);
                tag = (mk[0] == 0) ? "R3 flag bit" : (mk[0] == 1) ? "R5 payload bit" : "R7 R8 check bit";
            end
            chk(tag, int'(slot_bit), eb);
            chk("R11 level", int'(fifo_level), mf_d.size());
            chk("R10 irq_low", int'(irq_low), int'(enable && mf_d.size() < LOWM));
            chk("R9 ovf_flag", int'(ovf_flag), int'(m_ovf));
            if (prev_valid && prev_en && enable && !stb_at_edge)
                chk("R4 hold between strobes", int'(slot_bit), int'(prev_bit));
            prev_valid = 1; prev_bit = slot_bit; prev_en = enable;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        forever begin
            @(posedge clk); #1;
            slot_stb = stb_on && (($urandom % stb_div) == 0);
        end
    end

    task automatic wr(int d, bit e);
        @(posedge clk); #1;
        wr_en = 1; wr_data = 8'(d); wr_eom = e;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (!(mf_d.size() == 0 && m_phase == 0) && guard < 20000) begin
            @(posedge clk); guard++;
        end
        repeat (40) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R11 reset level", int'(fifo_level), 0);
        chk("R10 reset irq", int'(irq_low), 0);

        // R1: alternate sources while disabled
        stb_on = 1;
        for (int i = 0; i < 24; i++) begin
            @(posedge clk); #1;
            alt_sel = i[2]; ext_bit = i[0]; stuff_bit = ~i[1];
        end

        // R3: idle flags, strobe every cycle then sparse
        enable = 1; stb_div = 1;
        repeat (40) @(posedge clk);
        stb_div = 3;
        repeat (60) @(posedge clk);

        // R5 R6 R7: frame with long runs of ones across byte borders
        wr('hFF, 0); wr('h7E, 0); wr('hF8, 0); wr('h1F, 1);
        drain();

        // R9: fill past capacity with strobes paused
        stb_on = 0;
        repeat (4) @(posedge clk);
        for (int i = 0; i < DEPTH + 2; i++) wr(i * 17, i == DEPTH - 1);
        @(negedge clk);
        chk("R9 full level", int'(fifo_level), DEPTH);
        chk("R9 overflow set", int'(ovf_flag), 1);
        stb_on = 1; stb_div = 1;
        drain();

        // R8: underrun ends the frame without an end marker
        stb_div = 2;
        wr('hAA, 0); wr('h55, 0);
        drain();

        // random frames with random pacing
        for (int f = 0; f < 6; f++) begin
            int len;
            len = 1 + ($urandom % 6);
            stb_div = 1 + ($urandom % 3);
            for (int j = 0; j < len; j++) begin
                wr(int'($urandom % 256), j == len - 1);
                repeat ($urandom % 3) @(posedge clk);
            end
            drain();
        end

        // R2: disable in mid-frame, write while disabled
        stb_div = 1;
        wr('h3C, 0); wr('hFF, 0); wr('hFF, 0); wr('h81, 1);
        repeat (10) @(posedge clk);
        #1 enable = 0;
        wr('h12, 1);
        @(negedge clk);
        chk("R2 flushed level", int'(fifo_level), 0);
        chk("R2 irq masked", int'(irq_low), 0);
        chk("R2 ovf cleared", int'(ovf_flag), 0);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            alt_sel = i[0]; ext_bit = i[1]; stuff_bit = i[2];
        end
        @(posedge clk); #1 enable = 1;
        @(negedge clk);
        chk("R2 restart flag bit", int'(slot_bit), 0);
        wr('h0F, 1);
        drain();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule